// File: doc/BRIEF.md
# Flash Segment Window Decoder

This block keeps one window register per flash chip-select. Each register describes a contiguous piece of the flash aperture, with a start and an end given in 8 MB units. A lookup port takes a byte address and returns the chip-select whose window contains it, the byte offset of the address inside that window, and a hit indication.

Software changes a window through a simple indexed write port. The block does not store a written value as it is. It first forces the fixed fields back to their fixed values, then checks the result against the aperture limits, the window alignment and the other windows. Out-of-aperture values are dropped. Misaligned or overlapping values are stored but are reported. Each report sets its own sticky error flag, and a flag is cleared by pulsing its bit on the clear input. A read port returns any window register.

Top module: `seg_window_decoder`

## Requirements
- R1: A window register holds the end unit (address bits 30..23 of the end) in bits [31:24] and the start unit in bits [23:16]. Bits [15:0] always read as zero, whatever value was written to them. Window size is end minus start.
- R2: The start unit of chip-select 0 always equals the aperture base unit. A write to that register stores the aperture base as the start and keeps the written end.
- R3: When LAST_END_RO is set, the end unit of the last chip-select is always its reset default. Any written end for that register is replaced by the default end.
- R4: After the fixed fields are forced, a value whose end is at or below the aperture base unit, or whose start is above the aperture end unit, is rejected. The register keeps its old value and error flag bit 0 (range) is set.
- R5: An accepted value with a nonzero size and a start that is not a multiple of that size is stored, and error flag bit 1 (alignment) is set.
- R6: An accepted value whose window intersects the window of any other chip-select (new end > other start and new start < other end) is stored, and error flag bit 2 (overlap) is set.
- R7: A write whose data equals the current register contents has no effect: the register is unchanged and no flag is set.
- R8: Reset loads the registers with defaults. Chip-select 0 starts at the aperture base with CS0_UNITS units. Each following chip-select takes the next CSN_UNITS units. All error flags are 0 after reset.
- R9: The lookup returns hit=1, the lowest-numbered chip-select whose window satisfies start <= address unit < end, and offset = address minus the window start address. When no window matches, it returns hit=0, chip-select 0 and offset 0.
- R10: Error flags stay set until the matching bit of flag_clr is pulsed high for one cycle, which clears that bit only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Window register write strobe |
| wr_idx | input | IDX_W | Chip-select index for the write |
| wr_data | input | 32 | Write value |
| rd_idx | input | IDX_W | Chip-select index for the read |
| rd_data | output | 32 | Register value for rd_idx (0 when out of range) |
| flag_clr | input | 3 | Write-1-to-clear for the error flags |
| err_flags | output | 3 | Sticky flags: bit2 overlap, bit1 alignment, bit0 range |
| lk_addr | input | 32 | Byte address to decode |
| lk_hit | output | 1 | A window contains lk_addr |
| lk_cs | output | IDX_W | Chip-select of the matching window |
| lk_offset | output | 32 | Offset of lk_addr inside the matching window |

## Verification
The assertions assume that wr_idx addresses an existing chip-select whenever wr_en is high. They also assume that flag_clr is not pulsed for a flag in the same cycle as a write that sets that flag. The stimulus only writes to indices 0 to 2, and it issues each clear in a cycle of its own, after the write has completed. Lookup addresses are chosen below bit 31, so the unit comparison covers the whole address.

// File: rtl/seg_pkg.sv
package seg_pkg;
    localparam int UNIT_W     = 8;
    localparam int UNIT_SHIFT = 23;
    localparam int DATA_W     = 32;

    typedef logic [UNIT_W-1:0] unit_t;

    typedef struct packed {
        unit_t       end_u;
        unit_t       start_u;
        logic [15:0] zero;
    } seg_t;

    typedef struct packed {
        logic overlap;
        logic misalign;
        logic range;
    } flags_t;

    function automatic unit_t dflt_start(int idx, int base, int cs0u, int csnu);
        if (idx == 0) return unit_t'(base);
        return unit_t'(base + cs0u + csnu * (idx - 1));
    endfunction

    function automatic seg_t dflt_seg(int idx, int base, int cs0u, int csnu);
        seg_t s;
        s.start_u = dflt_start(idx, base, cs0u, csnu);
        s.end_u   = (idx == 0) ? unit_t'(base + cs0u)
                               : unit_t'(base + cs0u + csnu * idx);
        s.zero    = '0;
        return s;
    endfunction

    function automatic unit_t seg_size(seg_t s);
        return s.end_u - s.start_u;
    endfunction
endpackage

// File: rtl/seg_write_check.sv
module seg_write_check
    import seg_pkg::*;
#(
    parameter int NUM_CS      = 3,
    parameter int IDX_W       = 2,
    parameter int BASE_UNIT   = 64,
    parameter int APT_UNITS   = 32,
    parameter int CS0_UNITS   = 8,
    parameter int CSN_UNITS   = 4,
    parameter bit LAST_END_RO = 1'b1
) (
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        wr_idx,
    input  logic [DATA_W-1:0]       wr_data,
    input  seg_t [NUM_CS-1:0]       segs,
    output logic                    accept,
    output seg_t                    commit,
    output flags_t                  flag_set
);
    localparam int    LAST     = NUM_CS - 1;
    localparam int    APT_END  = BASE_UNIT + APT_UNITS;
    localparam seg_t  LAST_DEF = dflt_seg(LAST, BASE_UNIT, CS0_UNITS, CSN_UNITS);

    logic  idx_ok, changed, out_range, misalign, overlap;
    seg_t  req, cur;
    unit_t size;

    always_comb begin
        idx_ok = int'(wr_idx) < NUM_CS;
        cur    = idx_ok ? segs[wr_idx] : '0;
        req    = seg_t'(wr_data);
        commit = req;
        commit.zero = '0;
        if (wr_idx == '0)
            commit.start_u = unit_t'(BASE_UNIT);
        if (LAST_END_RO && int'(wr_idx) == LAST)
            commit.end_u = LAST_DEF.end_u;
        changed   = wr_data != DATA_W'(cur);
        out_range = (int'(commit.end_u) <= BASE_UNIT) ||
                    (int'(commit.start_u) > APT_END);
        size      = seg_size(commit);
        misalign  = (size != '0) && ((commit.start_u % size) != '0);
        overlap   = 1'b0;
        for (int j = 0; j < NUM_CS; j++) begin
            if (j != int'(wr_idx) &&
                commit.end_u > segs[j].start_u &&
                commit.start_u < segs[j].end_u)
                overlap = 1'b1;
        end
        accept            = wr_en && idx_ok && changed && !out_range;
        flag_set.range    = wr_en && idx_ok && changed && out_range;
        flag_set.misalign = accept && misalign;
        flag_set.overlap  = accept && overlap;
    end
endmodule

// File: rtl/seg_reg_bank.sv
module seg_reg_bank
    import seg_pkg::*;
#(
    parameter int NUM_CS      = 3,
    parameter int IDX_W       = 2,
    parameter int BASE_UNIT   = 64,
    parameter int CS0_UNITS   = 8,
    parameter int CSN_UNITS   = 4,
    parameter bit LAST_END_RO = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [IDX_W-1:0]  wr_idx,
    input  seg_t              commit,
    input  flags_t            flag_set,
    input  logic [2:0]        flag_clr,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output seg_t [NUM_CS-1:0] segs_q,
    output logic [2:0]        flags_q
);
    localparam int   LAST     = NUM_CS - 1;
    localparam seg_t LAST_DEF = dflt_seg(LAST, BASE_UNIT, CS0_UNITS, CSN_UNITS);

    for (genvar i = 0; i < NUM_CS; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                segs_q[i] <= dflt_seg(i, BASE_UNIT, CS0_UNITS, CSN_UNITS);
            else if (accept && int'(wr_idx) == i)
                segs_q[i] <= commit;
        end
        AST_LOW_ZERO: assert property (@(posedge clk) disable iff (rst)
            segs_q[i].zero == '0); // R1
    end

    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= (flags_q & ~flag_clr) | 3'(flag_set);
    end

    always_comb
        rd_data = (int'(rd_idx) < NUM_CS) ? DATA_W'(segs_q[rd_idx]) : '0;

    AST_CS0_START: assert property (@(posedge clk) disable iff (rst)
        segs_q[0].start_u == unit_t'(BASE_UNIT)); // R2
    AST_REJECT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !accept |=> $stable(segs_q)); // R4

    if (LAST_END_RO) begin : g_last_ro
        AST_LAST_END: assert property (@(posedge clk) disable iff (rst)
            segs_q[LAST].end_u == LAST_DEF.end_u); // R3
    end
endmodule

// File: rtl/seg_lookup.sv
module seg_lookup
    import seg_pkg::*;
#(
    parameter int NUM_CS = 3,
    parameter int IDX_W  = 2
) (
    input  seg_t [NUM_CS-1:0]  segs,
    input  logic [DATA_W-1:0]  lk_addr,
    output logic               lk_hit,
    output logic [IDX_W-1:0]   lk_cs,
    output logic [DATA_W-1:0]  lk_offset
);
    logic [DATA_W-UNIT_SHIFT-1:0] addr_u;

    always_comb begin
        addr_u    = lk_addr[DATA_W-1:UNIT_SHIFT];
        lk_hit    = 1'b0;
        lk_cs     = '0;
        lk_offset = '0;
        for (int i = NUM_CS - 1; i >= 0; i--) begin
            if (addr_u >= {1'b0, segs[i].start_u} && addr_u < {1'b0, segs[i].end_u}) begin
                lk_hit    = 1'b1;
                lk_cs     = IDX_W'(i);
                lk_offset = lk_addr - {1'b0, segs[i].start_u, {UNIT_SHIFT{1'b0}}};
            end
        end
    end
endmodule

// File: rtl/seg_window_decoder.sv
module seg_window_decoder
    import seg_pkg::*;
#(
    parameter int NUM_CS      = 3,
    parameter int BASE_UNIT   = 64,
    parameter int APT_UNITS   = 32,
    parameter int CS0_UNITS   = 8,
    parameter int CSN_UNITS   = 4,
    parameter bit LAST_END_RO = 1'b1,
    localparam int IDX_W      = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [31:0]       wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [31:0]       rd_data,
    input  logic [2:0]        flag_clr,
    output logic [2:0]        err_flags,
    input  logic [31:0]       lk_addr,
    output logic              lk_hit,
    output logic [IDX_W-1:0]  lk_cs,
    output logic [31:0]       lk_offset
);
    seg_t [NUM_CS-1:0] segs;
    seg_t              commit;
    flags_t            flag_set;
    logic              accept;

    seg_write_check #(
        .NUM_CS(NUM_CS), .IDX_W(IDX_W), .BASE_UNIT(BASE_UNIT), .APT_UNITS(APT_UNITS),
        .CS0_UNITS(CS0_UNITS), .CSN_UNITS(CSN_UNITS), .LAST_END_RO(LAST_END_RO)
    ) i_check (
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .segs(segs),
        .accept(accept), .commit(commit), .flag_set(flag_set)
    );

    seg_reg_bank #(
        .NUM_CS(NUM_CS), .IDX_W(IDX_W), .BASE_UNIT(BASE_UNIT),
        .CS0_UNITS(CS0_UNITS), .CSN_UNITS(CSN_UNITS), .LAST_END_RO(LAST_END_RO)
    ) i_bank (
        .clk(clk), .rst(rst), .accept(accept), .wr_idx(wr_idx), .commit(commit),
        .flag_set(flag_set), .flag_clr(flag_clr), .rd_idx(rd_idx), .rd_data(rd_data),
        .segs_q(segs), .flags_q(err_flags)
    );

    seg_lookup #(.NUM_CS(NUM_CS), .IDX_W(IDX_W)) i_lookup (
        .segs(segs), .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_cs(lk_cs), .lk_offset(lk_offset)
    );

    AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (rst)
        ((err_flags & ~$past(err_flags)) != '0) |-> $past(wr_en)); // R10
    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (rst)
        !lk_hit |-> (lk_offset == '0 && lk_cs == '0)); // R9
    AST_HIT_INSIDE: assert property (@(posedge clk) disable iff (rst)
        lk_hit |-> ((lk_offset >> UNIT_SHIFT) < 32'(seg_size(segs[lk_cs])))); // R9
endmodule

// File: tb/test_seg_window_decoder.sv
`timescale 1ns/1ps
module test_seg_window_decoder;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_idx = '0;
    logic [31:0] rd_data;
    logic [2:0]  flag_clr = '0;
    logic [2:0]  err_flags;
    logic [31:0] lk_addr = '0;
    logic        lk_hit;
    logic [1:0]  lk_cs;
    logic [31:0] lk_offset;

    always #2.5 clk = ~clk;

    seg_window_decoder i_seg_window_decoder (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_idx(rd_idx), .rd_data(rd_data), .flag_clr(flag_clr), .err_flags(err_flags),
        .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_cs(lk_cs), .lk_offset(lk_offset)
    );

    typedef struct {
        int          kind;   // 0 read, 1 lookup, 2 flags
        logic [31:0] exp;
        logic        exp_hit;
        logic [1:0]  exp_cs;
        string       tag;
    } item_t;

    item_t q[$];
    int    checks = 0;
    int    errors = 0;
    bit    done = 0;

    task automatic exp_rd(input logic [1:0] idx, input logic [31:0] e, input string tag);
        item_t it;
        @(posedge clk); #1;
        rd_idx = idx;
        it.kind = 0; it.exp = e; it.exp_hit = 0; it.exp_cs = idx; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic exp_lk(input logic [31:0] a, input logic h, input logic [1:0] cs,
                          input logic [31:0] off, input string tag);
        item_t it;
        @(posedge clk); #1;
        lk_addr = a;
        it.kind = 1; it.exp = off; it.exp_hit = h; it.exp_cs = cs; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic exp_fl(input logic [2:0] f, input string tag);
        item_t it;
        @(posedge clk); #1;
        it.kind = 2; it.exp = {29'b0, f}; it.exp_hit = 0; it.exp_cs = 0; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic wr(input logic [1:0] idx, input logic [31:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_idx = idx; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic clr(input logic [2:0] m);
        @(posedge clk); #1;
        flag_clr = m;
        @(posedge clk); #1;
        flag_clr = '0;
    endtask

    always @(negedge clk) begin
        if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            checks++;
            case (it.kind)
                0: if (rd_data !== it.exp) begin
                       errors++;
                       $display("FAIL %s: rd_data=%h expected %h", it.tag, rd_data, it.exp);
                   end
                1: if (lk_hit !== it.exp_hit || lk_cs !== it.exp_cs || lk_offset !== it.exp) begin
                       errors++;
                       $display("FAIL %s: hit/cs/off=%b/%0d/%h expected %b/%0d/%h", it.tag,
                                lk_hit, lk_cs, lk_offset, it.exp_hit, it.exp_cs, it.exp);
                   end
                default: if (err_flags !== it.exp[2:0]) begin
                       errors++;
                       $display("FAIL %s: err_flags=%b expected %b", it.tag, err_flags, it.exp[2:0]);
                   end
            endcase
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R8 reset defaults
        exp_rd(0, 32'h4840_0000, "R8 cs0 default");
        exp_rd(1, 32'h4C48_0000, "R8 cs1 default");
        exp_rd(2, 32'h504C_0000, "R8 cs2 default");
        exp_fl(3'b000, "R8 flags reset");
        // R9 lookup under defaults
        exp_lk(32'h2000_0010, 1, 0, 32'h0000_0010, "R9 cs0 hit");
        exp_lk(32'h2410_0000, 1, 1, 32'h0010_0000, "R9 cs1 hit");
        exp_lk(32'h2600_0000, 1, 2, 32'h0000_0000, "R9 cs2 start");
        exp_lk(32'h2800_0000, 0, 0, 32'h0, "R9 miss at end");
        exp_lk(32'h1FFF_FFFF, 0, 0, 32'h0, "R9 miss below");
        // R2 start of cs0 forced, R6 overlap accepted
        wr(0, 32'h5044_0000);
        exp_rd(0, 32'h5040_0000, "R2 cs0 start forced");
        exp_fl(3'b100, "R6 overlap flag");
        exp_lk(32'h2400_0000, 1, 0, 32'h0400_0000, "R9 lowest cs wins");
        exp_fl(3'b100, "R10 flag sticky");
        clr(3'b100);
        exp_fl(3'b000, "R10 flag cleared");
        wr(0, 32'h4840_0000);
        exp_fl(3'b000, "R6 no overlap on restore");
        // R3 last end locked
        wr(2, 32'h5850_0000);
        exp_rd(2, 32'h5050_0000, "R3 cs2 end forced");
        exp_lk(32'h2600_0000, 0, 0, 32'h0, "R9 empty window misses");
        // R4 rejects
        wr(1, 32'h3F30_0000);
        exp_rd(1, 32'h4C48_0000, "R4 below base rejected");
        exp_fl(3'b001, "R4 range flag");
        clr(3'b001);
        wr(1, 32'h7061_0000);
        exp_rd(1, 32'h4C48_0000, "R4 past end rejected");
        exp_fl(3'b001, "R4 range flag again");
        clr(3'b001);
        wr(1, 32'h6260_0000);
        exp_rd(1, 32'h6260_0000, "R4 start at aperture end accepted");
        exp_fl(3'b000, "R4 no flag at boundary");
        // R5 alignment
        wr(1, 32'h4E4A_0000);
        exp_rd(1, 32'h4E4A_0000, "R5 misaligned stored");
        exp_fl(3'b010, "R5 align flag");
        clr(3'b010);
        exp_fl(3'b000, "R10 align cleared");
        // R7 equal write ignored
        wr(1, 32'h4E4A_0000);
        exp_fl(3'b000, "R7 equal write no flag");
        exp_rd(1, 32'h4E4A_0000, "R7 register unchanged");
        // R1 low bits zero
        wr(1, 32'h4C48_ABCD);
        exp_rd(1, 32'h4C48_0000, "R1 low bits zero");
        exp_fl(3'b000, "R1 aligned no flag");
        exp_lk(32'h24AB_C000, 1, 1, 32'h00AB_C000, "R9 offset in cs1");
        repeat (4) @(posedge clk);
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule